// File: doc/BRIEF.md
# Video Output Rounding and Clipping Unit

This block turns a 16-bit signed internal result into the registered output word. It keeps a selectable number of significant bits, from 16 down to 8. It rounds at the bit just below the kept LSB and clears every bit beneath it. If rounding pushes a positive value past the largest code, the result saturates instead of wrapping. Two video modes clamp the kept bits so that the reserved timing-reference codes at both ends of a 10-bit or 8-bit range never appear in the data.

The rounded value can be sent out in three formats: two's complement, offset binary, or inverted offset binary. A result is captured only on a cycle in which the valid strobe is high. An active-low enable controls the output pins. When the enable is high, the pins float at once, without waiting for a clock edge. A separate drive flag reports whether the pins are being driven.

Top module: `vid_round_clip`

## Requirements
- R1: A synchronous, active-high reset clears the output register to 0x0000.
- R2: The output register loads a new result only on a rising edge with `vld_i` high. At any other edge it keeps its value.
- R3: With `ext_en` low, `rnd_code` value c (0 to 7) keeps 16−c bits. The bench's examples are 000→16, 011→13 and 111→9. When c > 0, a one is added at bit c−1 and bits c−1..0 are then forced to zero. With `ext_en` high, codes 000, 001, 010, 011 and 111 act the same way.
- R4: If rounding overflows past 0x7FFF, the result becomes the largest positive value of the selected width: 0x7FFF with its dropped bits cleared (0x7F80 for 9 bits). It does not wrap. Negative values cannot overflow.
- R5: With `ext_en` high, code 100 keeps 8 bits (adds 0x0080, clears bits 7..0) and does not clip.
- R6: With `ext_en` high, code 110 keeps 10 bits. The signed top 10 bits are clamped to −508..507, so their offset-binary code lies in 0x004..0x3FB. In 16-bit terms the clamp range is 0x8100..0x7EC0. The clamp is applied before format conversion.
- R7: With `ext_en` high, code 101 keeps 8 bits. The signed top 8 bits are clamped to −127..126, so their offset-binary code lies in 0x01..0xFE. In 16-bit terms the clamp range is 0x8100..0x7E00.
- R8: With `tc_fmt` high, the output is two's complement, whatever the value of `uns_en`.
- R9: With `tc_fmt` low and `uns_en` low, bits 14 and below of the signed result are inverted and bit 15 is kept (inverted offset binary). Bits below the kept LSB stay zero.
- R10: With `tc_fmt` low and `uns_en` high, only bit 15 is inverted (offset binary).
- R11: While `oe_n` is high, `q_o` is high impedance and `q_drv_o` is low. This takes effect with no clock edge. The register keeps its content and shows it again once `oe_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Result valid; loads the output register |
| res_i | input | 16 | Signed internal result |
| rnd_code | input | 3 | Rounding width code |
| ext_en | input | 1 | Enables the 8-bit and video-range codes |
| uns_en | input | 1 | Unsigned (offset binary) output mode |
| tc_fmt | input | 1 | 1: two's complement; 0: offset formats |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| q_o | output | 16 | Output word, high impedance while disabled |
| q_drv_o | output | 1 | High while `q_o` is driven |

## Verification
Four properties are checked on every clock:
- the register holds when no valid strobe arrives;
- the low bits are cleared for 9-bit rounding;
- both video clamps keep the value inside their range in two's-complement output;
- the full-width code in two's complement passes the input through unchanged.

Other behaviours can only be shown by the bench's directed scenarios, which compare against exact expected words:
- the exact rounding carry;
- saturation to the width-specific maximum;
- both offset formats;
- the rule that masked bits stay zero after inversion;
- the fact that the output enable acts between clock edges.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int SH_W = 5;

  typedef enum logic [1:0] {
    FMT_TWOS = 2'd0,
    FMT_IOB  = 2'd1,
    FMT_OB   = 2'd2
  } out_fmt_e;
endpackage

// File: rtl/vrc_mode_dec.sv
module vrc_mode_dec
  import vrc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CODE_W      = 3,
  parameter int EXT8_W      = 8,
  parameter int VID10_W     = 10,
  parameter int VID10_GUARD = 4,
  parameter int VID8_W      = 8,
  parameter int VID8_GUARD  = 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic              ext,
  output logic [SH_W-1:0]   drop,
  output logic              clip_en,
  output logic [SH_W-1:0]   guard
);
  localparam logic [CODE_W-1:0] C_EXT8  = CODE_W'(4);
  localparam logic [CODE_W-1:0] C_VID8  = CODE_W'(5);
  localparam logic [CODE_W-1:0] C_VID10 = CODE_W'(6);

  always_comb begin
    drop    = SH_W'(code);
    clip_en = 1'b0;
    guard   = '0;
    if (ext) begin
      case (code)
        C_EXT8:  drop = SH_W'(DATA_W - EXT8_W);
        C_VID10: begin
          drop    = SH_W'(DATA_W - VID10_W);
          clip_en = 1'b1;
          guard   = SH_W'(VID10_GUARD);
        end
        C_VID8: begin
          drop    = SH_W'(DATA_W - VID8_W);
          clip_en = 1'b1;
          guard   = SH_W'(VID8_GUARD);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vrc_round_sat.sv
module vrc_round_sat
  import vrc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x,
  input  logic [SH_W-1:0]   drop,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] y
);
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W:0] half;
  logic [DATA_W:0] sum;

  always_comb begin
    mask = {DATA_W{1'b1}} << drop;
    half = (drop == '0) ? '0 : ((DATA_W+1)'(1) << (drop - SH_W'(1)));
    sum  = {x[DATA_W-1], x} + half;
    if (sum[DATA_W] != sum[DATA_W-1])
      y = MAX_POS & mask;
    else
      y = sum[DATA_W-1:0] & mask;
  end
endmodule

// File: rtl/vrc_clip.sv
module vrc_clip
  import vrc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] y,
  input  logic [SH_W-1:0]   drop,
  input  logic [SH_W-1:0]   guard,
  input  logic              clip_en,
  output logic [DATA_W-1:0] z
);
  localparam logic signed [DATA_W:0] HALF_RANGE = (DATA_W+1)'(1) << (DATA_W-1);

  logic signed [DATA_W:0] hi_lim;
  logic signed [DATA_W:0] lo_lim;
  logic signed [DATA_W:0] ys;

  always_comb begin
    ys     = {y[DATA_W-1], y};
    hi_lim = HALF_RANGE - (((DATA_W+1)'(guard) + (DATA_W+1)'(1)) << drop);
    lo_lim = ((DATA_W+1)'(guard) << drop) - HALF_RANGE;
    z      = y;
    if (clip_en) begin
      if (ys > hi_lim)      z = hi_lim[DATA_W-1:0];
      else if (ys < lo_lim) z = lo_lim[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/vrc_fmt.sv
module vrc_fmt
  import vrc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] z,
  input  logic [DATA_W-1:0] mask,
  input  out_fmt_e          fmt,
  output logic [DATA_W-1:0] w
);
  localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] flip;

  always_comb begin
    case (fmt)
      FMT_IOB: flip = ~MSB_ONLY;
      FMT_OB:  flip = MSB_ONLY;
      default: flip = '0;
    endcase
    w = (z ^ flip) & mask;
  end
endmodule

// File: rtl/vid_round_clip.sv
module vid_round_clip
  import vrc_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CODE_W      = 3,
  parameter int EXT8_W      = 8,
  parameter int VID10_W     = 10,
  parameter int VID10_GUARD = 4,
  parameter int VID8_W      = 8,
  parameter int VID8_GUARD  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [CODE_W-1:0] rnd_code,
  input  logic              ext_en,
  input  logic              uns_en,
  input  logic              tc_fmt,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q_o,
  output logic              q_drv_o
);
  logic [SH_W-1:0]   drop;
  logic [SH_W-1:0]   guard;
  logic              clip_en;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] rounded;
  logic [DATA_W-1:0] clipped;
  logic [DATA_W-1:0] formatted;
  logic [DATA_W-1:0] out_q;
  out_fmt_e          fmt_sel;

  always_comb begin
    if (tc_fmt)      fmt_sel = FMT_TWOS;
    else if (uns_en) fmt_sel = FMT_OB;
    else             fmt_sel = FMT_IOB;
  end

  vrc_mode_dec #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .EXT8_W(EXT8_W),
    .VID10_W(VID10_W), .VID10_GUARD(VID10_GUARD),
    .VID8_W(VID8_W), .VID8_GUARD(VID8_GUARD)
  ) u_dec (
    .code(rnd_code), .ext(ext_en), .drop(drop), .clip_en(clip_en), .guard(guard)
  );

  vrc_round_sat #(.DATA_W(DATA_W)) u_rnd (
    .x(res_i), .drop(drop), .mask(mask), .y(rounded)
  );

  vrc_clip #(.DATA_W(DATA_W)) u_clip (
    .y(rounded), .drop(drop), .guard(guard), .clip_en(clip_en), .z(clipped)
  );

  vrc_fmt #(.DATA_W(DATA_W)) u_fmt (
    .z(clipped), .mask(mask), .fmt(fmt_sel), .w(formatted)
  );

  always_ff @(posedge clk) begin
    if (rst)        out_q <= '0;
    else if (vld_i) out_q <= formatted;
  end

  assign q_o     = oe_n ? {DATA_W{1'bz}} : out_q;
  assign q_drv_o = ~oe_n;
endmodule

// File: rtl/vid_round_clip_chk.sv
module vid_round_clip_chk #(
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              vld_i,
  input logic [DATA_W-1:0] res_i,
  input logic [CODE_W-1:0] rnd_code,
  input logic              ext_en,
  input logic              uns_en,
  input logic              tc_fmt,
  input logic [DATA_W-1:0] out_q
);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> $stable(out_q));

  a_r3_low_clear: assert property (@(posedge clk) disable iff (rst)
    vld_i && !ext_en && rnd_code == CODE_W'(7) |=> out_q[6:0] == 7'd0);

  a_r6_vid10_range: assert property (@(posedge clk) disable iff (rst)
    vld_i && ext_en && rnd_code == CODE_W'(6) && tc_fmt |=>
      ($signed(out_q) <= $signed(16'h7EC0)) && ($signed(out_q) >= $signed(16'h8100)));

  a_r7_vid8_range: assert property (@(posedge clk) disable iff (rst)
    vld_i && ext_en && rnd_code == CODE_W'(5) && tc_fmt |=>
      ($signed(out_q) <= $signed(16'h7E00)) && ($signed(out_q) >= $signed(16'h8100))
      && out_q[7:0] == 8'd0);

  a_r8_full_pass: assert property (@(posedge clk) disable iff (rst)
    vld_i && rnd_code == '0 && tc_fmt && !uns_en |=> out_q == $past(res_i));
endmodule

bind vid_round_clip vid_round_clip_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .vld_i(vld_i), .res_i(res_i), .rnd_code(rnd_code),
  .ext_en(ext_en), .uns_en(uns_en), .tc_fmt(tc_fmt), .out_q(out_q)
);

// File: tb/vid_round_clip_tb_top.sv
module vid_round_clip_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        vld_i = 0;
  logic [15:0] res_i = '0;
  logic [2:0]  rnd_code = '0;
  logic        ext_en = 0;
  logic        uns_en = 0;
  logic        tc_fmt = 1;
  logic        oe_n = 0;
  wire  [15:0] q_o;
  wire         q_drv_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  vid_round_clip dut_i (
    .clk(clk), .rst(rst), .vld_i(vld_i), .res_i(res_i), .rnd_code(rnd_code),
    .ext_en(ext_en), .uns_en(uns_en), .tc_fmt(tc_fmt), .oe_n(oe_n),
    .q_o(q_o), .q_drv_o(q_drv_o)
  );

  function automatic logic [15:0] model(input logic [15:0] x, input logic [2:0] c,
                                        input logic e, input logic f, input logic u);
    int drop = int'(c);
    int g = 0;
    bit cl = 0;
    int v;
    logic [15:0] r;
    logic [15:0] m;
    if (e && c == 3'b100) drop = 8;
    if (e && c == 3'b110) begin drop = 6; cl = 1; g = 4; end
    if (e && c == 3'b101) begin drop = 8; cl = 1; g = 1; end
    v = int'($signed(x));
    if (drop > 0) v = v + (1 << (drop - 1));
    if (v > 32767) v = 32767;
    v = v & ~((1 << drop) - 1);
    if (cl) begin
      if (v > 32768 - ((g + 1) << drop)) v = 32768 - ((g + 1) << drop);
      if (v < -32768 + (g << drop)) v = -32768 + (g << drop);
    end
    m = 16'hFFFF << drop;
    r = v[15:0];
    if (!f) r = r ^ (u ? 16'h8000 : 16'h7FFF);
    return r & m;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] x, input logic [2:0] c,
                       input logic e, input logic f, input logic u);
    @(negedge clk);
    res_i = x; rnd_code = c; ext_en = e; tc_fmt = f; uns_en = u; vld_i = 1;
    @(negedge clk);
    vld_i = 0;
    chk(req, q_o, model(x, c, e, f, u));
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset", q_o, 16'h0000);
    rst = 0;
  endtask

  task automatic t_round;
    apply("R3 code000", 16'h1234, 3'd0, 0, 1, 0);
    chk("R3 literal", q_o, 16'h1234);
    apply("R3 code011 up", 16'h1235, 3'd3, 0, 1, 0);
    chk("R3 literal up", q_o, 16'h1238);
    apply("R3 code011 down", 16'h1233, 3'd3, 0, 1, 0);
    chk("R3 literal down", q_o, 16'h1230);
    apply("R3 code111 neg", 16'h8000, 3'd7, 0, 1, 0);
    apply("R3 ext code011", 16'hABCD, 3'd3, 1, 1, 0);
    apply("R3 ext code111", 16'h4321, 3'd7, 1, 1, 0);
  endtask

  task automatic t_sat;
    apply("R4 sat 9bit", 16'h7FF0, 3'd7, 0, 1, 0);
    chk("R4 literal", q_o, 16'h7F80);
    apply("R4 sat 15bit", 16'h7FFF, 3'd1, 0, 1, 0);
    chk("R4 literal 15", q_o, 16'h7FFE);
  endtask

  task automatic t_ext8;
    apply("R5 ext 8bit", 16'h12C0, 3'd4, 1, 1, 0);
    chk("R5 literal", q_o, 16'h1300);
    apply("R5 no clip", 16'h7F00, 3'd4, 1, 1, 0);
    chk("R5 no clip literal", q_o, 16'h7F00);
    apply("R3 code100 no ext", 16'h12C8, 3'd4, 0, 1, 0);
  endtask

  task automatic t_video;
    apply("R6 vid10 hi", 16'h7FF0, 3'd6, 1, 1, 0);
    chk("R6 literal hi", q_o, 16'h7EC0);
    apply("R6 vid10 lo", 16'h8000, 3'd6, 1, 1, 0);
    chk("R6 literal lo", q_o, 16'h8100);
    apply("R6 vid10 mid", 16'h0123, 3'd6, 1, 1, 0);
    apply("R6 vid10 offset", 16'h7FF0, 3'd6, 1, 0, 1);
    chk("R6 offset literal", q_o, 16'hFEC0);
    apply("R7 vid8 hi", 16'h7FFF, 3'd5, 1, 1, 0);
    chk("R7 literal hi", q_o, 16'h7E00);
    apply("R7 vid8 lo", 16'h8000, 3'd5, 1, 1, 0);
    chk("R7 literal lo", q_o, 16'h8100);
    apply("R7 vid8 offset lo", 16'h8000, 3'd5, 1, 0, 1);
    chk("R7 offset literal", q_o, 16'h0100);
  endtask

  task automatic t_formats;
    apply("R8 twos with uns", 16'h9234, 3'd0, 0, 1, 1);
    chk("R8 literal", q_o, 16'h9234);
    apply("R9 iob", 16'h1238, 3'd3, 0, 0, 0);
    chk("R9 literal", q_o, 16'h6DC0);
    apply("R9 iob neg", 16'hF00F, 3'd2, 0, 0, 0);
    apply("R10 ob", 16'h1234, 3'd0, 0, 0, 1);
    chk("R10 literal", q_o, 16'h9234);
  endtask

  task automatic t_hold;
    apply("R2 load", 16'h0AB0, 3'd0, 0, 1, 0);
    @(negedge clk);
    res_i = 16'h5555; vld_i = 0;
    repeat (3) @(negedge clk);
    chk("R2 hold", q_o, 16'h0AB0);
  endtask

  task automatic t_oe;
    apply("R11 prep", 16'h3C3C, 3'd0, 0, 1, 0);
    @(posedge clk);
    #3 oe_n = 1;
    #2;
    n_chk++;
    if (q_drv_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 drive off: got %b expected 0", q_drv_o);
    end
    @(negedge clk);
    #3 oe_n = 0;
    #2;
    n_chk++;
    if (q_drv_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R11 drive on: got %b expected 1", q_drv_o);
    end
    chk("R11 content kept", q_o, 16'h3C3C);
  endtask

  initial begin
    t_reset();
    t_round();
    t_sat();
    t_ext8();
    t_video();
    t_formats();
    t_hold();
    t_oe();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule